// File: doc/BRIEF.md
# Dual-Mode Host Bus Access Unit

This block sits between a host processor and the register file of a small timekeeping peripheral. The host uses an 8-bit multiplexed address/data bus. A static strap input picks one of two strobe styles. In strobe-pulse mode, `ds_i` is a positive pulse late in the cycle, and a level on `rw_i` gives the direction. In output-enable mode, `ds_i` is an active-low read enable, and a separate active-low write strobe `we_ni` carries writes. All bus inputs pass through a synchroniser into the system clock. Edges are detected there, and address and data are taken from a delay line kept in step with the strobes.

The unit latches the address and the chip-select state at the falling edge of the address strobe. It controls the output enable of the shared bus and issues single-cycle write pulses to the external register file. It also holds the control byte and the interrupt flag byte itself. The bus reset input blocks all accesses while it is low. When power is reported good, it also clears the interrupt enables, the square-wave enable and all interrupt flags. It leaves the upper control bits alone, and it releases the interrupt request.

Top module: `hbus_access_unit`

## Requirements
- R1: The address and the chip-select state are latched at the falling edge of `as_i`. A cycle whose `cs_ni` was high at that edge neither drives the bus nor produces a write.
- R2: With `mode_ds_i`=1 and `rw_i`=1, `ad_oe_o` is high and `ad_o` carries the selected register only while `ds_i` is high, lagging the pin by the synchroniser depth. External addresses return `reg_rdata_i`.
- R3: With `mode_ds_i`=1 and `rw_i`=0, the data on the bus is captured at the falling edge of `ds_i`. For an external address this gives exactly one `reg_we_o` pulse carrying `reg_addr_o` and `reg_wdata_o`. Writes to the control address (default 0x0B) update the internal control byte and give no pulse.
- R4: With `mode_ds_i`=0, the bus is driven only while `ds_i` is low, as an active-low output enable.
- R5: With `mode_ds_i`=0, write data is captured at the rising edge of `we_ni`, and the write completes as in R3.
- R6: While `bus_rst_ni` is low, the bus is not driven, writes are dropped and any selection is lost. A new cycle after release works normally.
- R7: While `bus_rst_ni` is low and `pwr_ok_i` is high, control bits 0..3 are cleared. These are bit0 periodic enable, bit1 alarm enable, bit2 update enable and bit3 square-wave enable (`sqw_en_o`). Bits 7..4 are kept, all flags are cleared and `irq_drive_o` is low.
- R8: While `pwr_ok_i` is low, a low `bus_rst_ni` leaves the control byte unchanged.
- R9: `evt_i` bits 0..2 set flag bits 0..2 (periodic, alarm, update) of the flag register at the flag address (default 0x0C). Bit 7 is the OR of each flag ANDed with its enable, and `irq_drive_o` follows it. Completing a read of the flag register clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| mode_ds_i | input | 1 | Strap: 1 strobe-pulse mode, 0 output-enable mode |
| bus_rst_ni | input | 1 | Active-low bus reset pin |
| pwr_ok_i | input | 1 | Supply above power-fail threshold |
| cs_ni | input | 1 | Active-low chip select |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe or active-low read enable |
| rw_i | input | 1 | Direction level, 1 read (strobe-pulse mode) |
| we_ni | input | 1 | Active-low write strobe (output-enable mode) |
| ad_i | input | 8 | Multiplexed bus, input side |
| ad_o | output | 8 | Multiplexed bus, read data |
| ad_oe_o | output | 1 | Bus output enable |
| reg_addr_o | output | 8 | Latched register address |
| reg_wdata_o | output | 8 | Captured write data |
| reg_we_o | output | 1 | Write pulse to external register file |
| reg_rdata_i | input | 8 | Read data from external register file |
| evt_i | input | 3 | Event pulses: periodic, alarm, update |
| irq_drive_o | output | 1 | Pull interrupt line low; 0 means released |
| sqw_en_o | output | 1 | Square-wave output enable |

## Verification
The bench builds the unit with a synchroniser depth of 3 instead of the default 2. This shows that drive windows and capture edges follow the depth parameter, and that the data delay line stays aligned with the strobes. The control and flag addresses keep their defaults, 0x0B and 0x0C. With these values, internal and external accesses can be mixed in both strap modes. Reset is applied partway through reads and writes, and flags can be cleared by read with their enables both on and off.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BUS_W = 8;
  localparam int N_SRC = 3;

  // control byte bits (enables share index with flag sources)
  localparam int CB_PIE = 0;
  localparam int CB_AIE = 1;
  localparam int CB_UIE = 2;
  localparam int CB_SQW = 3;
  localparam int N_CLR  = 4;
  // flag byte summary bit
  localparam int FB_IRQ = 7;

  typedef struct packed {
    logic [BUS_W-1:0] ad;
    logic             pwr_ok;
    logic             rst_n;
    logic             rw;
    logic             cs_n;
    logic             we_n;
    logic             ds;
    logic             as;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);

  localparam bus_smp_t SMP_RST = '{ad: '0, pwr_ok: 1'b0, rst_n: 1'b0, rw: 1'b1,
                                   cs_n: 1'b1, we_n: 1'b1, ds: 1'b0, as: 1'b0};
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {DEPTH{RST_VAL}};
    else         pipe_q <= {pipe_q[DEPTH-2:0], d_i};
  end

  // cur: synchronised level; prev: one cycle older, aligned data for edges
  assign cur_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/hbus_bus_fsm.sv
module hbus_bus_fsm
  import hbus_pkg::*;
#(
  parameter logic [BUS_W-1:0] CTRL_ADDR = 8'h0B,
  parameter logic [BUS_W-1:0] FLAG_ADDR = 8'h0C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_ds_i,
  input  bus_smp_t         cur_i,
  input  bus_smp_t         prev_i,
  input  logic [BUS_W-1:0] ctrl_rd_i,
  input  logic [BUS_W-1:0] flag_rd_i,
  input  logic [BUS_W-1:0] ext_rd_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [BUS_W-1:0] addr_o,
  output logic [BUS_W-1:0] wdata_o,
  output logic             wr_o,
  output logic             rd_end_o
);
  logic             sel_q, wr_q, rd_end_q;
  logic [BUS_W-1:0] addr_q, wdata_q;
  logic             ok, as_fall, ds_fall, ds_rise, we_rise;
  logic             wr_fire, rd_fire;

  assign ok      = cur_i.rst_n;
  assign as_fall = prev_i.as & ~cur_i.as;
  assign ds_fall = prev_i.ds & ~cur_i.ds;
  assign ds_rise = ~prev_i.ds & cur_i.ds;
  assign we_rise = ~prev_i.we_n & cur_i.we_n;

  always_comb begin
    if (mode_ds_i) begin
      wr_fire = sel_q & ok & ds_fall & ~prev_i.rw;
      rd_fire = sel_q & ok & ds_fall & prev_i.rw;
      ad_oe_o = sel_q & ok & cur_i.ds & cur_i.rw;
    end else begin
      wr_fire = sel_q & ok & we_rise;
      rd_fire = sel_q & ok & ds_rise;
      ad_oe_o = sel_q & ok & ~cur_i.ds;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      rd_end_q <= 1'b0;
    end else begin
      wr_q     <= wr_fire;
      rd_end_q <= rd_fire;
      if (!ok) begin
        sel_q <= 1'b0;
      end else if (as_fall) begin
        sel_q  <= ~prev_i.cs_n;
        addr_q <= prev_i.ad;
      end
      if (wr_fire) wdata_q <= prev_i.ad;
    end
  end

  always_comb begin
    if (addr_q == CTRL_ADDR)      ad_o = ctrl_rd_i;
    else if (addr_q == FLAG_ADDR) ad_o = flag_rd_i;
    else                          ad_o = ext_rd_i;
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign wr_o     = wr_q;
  assign rd_end_o = rd_end_q;

  logic unused_smp;
  assign unused_smp = ^{cur_i.ad, cur_i.cs_n, cur_i.pwr_ok, cur_i.we_n, cur_i.as,
                        prev_i.pwr_ok, prev_i.rst_n, prev_i.we_n};

  p_wr_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  p_wr_needs_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> $past(sel_q));
endmodule

// File: rtl/hbus_ctl_regs.sv
module hbus_ctl_regs
  import hbus_pkg::*;
#(
  parameter logic [BUS_W-1:0] CTRL_ADDR = 8'h0B,
  parameter logic [BUS_W-1:0] FLAG_ADDR = 8'h0C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_ok_i,
  input  logic             rst_clr_i,
  input  logic             wr_i,
  input  logic             rd_end_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [N_SRC-1:0] evt_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic [BUS_W-1:0] flag_o,
  output logic             irq_drive_o,
  output logic             sqw_en_o
);
  logic [BUS_W-1:0] ctrl_q;
  logic [N_SRC-1:0] flg_q;
  logic             rd_clr, irqf;

  assign rd_clr = rd_end_i & (addr_i == FLAG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (rst_clr_i)                         ctrl_q[N_CLR-1:0] <= '0;
    else if (wr_i && (addr_i == CTRL_ADDR))     ctrl_q <= wdata_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flg_q[i] <= 1'b0;
      else if (rst_clr_i) flg_q[i] <= 1'b0;
      else if (evt_i[i])  flg_q[i] <= 1'b1;
      else if (rd_clr)    flg_q[i] <= 1'b0;
    end
  end

  assign irqf = |(flg_q & ctrl_q[N_SRC-1:0]);

  always_comb begin
    flag_o              = '0;
    flag_o[N_SRC-1:0]   = flg_q;
    flag_o[FB_IRQ]      = irqf;
  end

  assign ctrl_o      = ctrl_q;
  assign irq_drive_o = irqf & bus_ok_i;
  assign sqw_en_o    = ctrl_q[CB_SQW];

  p_rst_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_clr_i |=> (ctrl_q[N_CLR-1:0] == '0) && (flg_q == '0));
  p_rst_keeps_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_clr_i |=> $stable(ctrl_q[BUS_W-1:N_CLR]));
endmodule

// File: rtl/hbus_access_unit.sv
module hbus_access_unit
  import hbus_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0] CTRL_ADDR   = 8'h0B,
  parameter logic [BUS_W-1:0] FLAG_ADDR   = 8'h0C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_ds_i,
  input  logic             bus_rst_ni,
  input  logic             pwr_ok_i,
  input  logic             cs_ni,
  input  logic             as_i,
  input  logic             ds_i,
  input  logic             rw_i,
  input  logic             we_ni,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [BUS_W-1:0] reg_addr_o,
  output logic [BUS_W-1:0] reg_wdata_o,
  output logic             reg_we_o,
  input  logic [BUS_W-1:0] reg_rdata_i,
  input  logic [N_SRC-1:0] evt_i,
  output logic             irq_drive_o,
  output logic             sqw_en_o
);
  bus_smp_t         smp_in, smp_cur, smp_prev;
  logic [BUS_W-1:0] ctrl_rd, flag_rd, addr, wdata;
  logic             wr, rd_end, rst_clr;

  always_comb begin
    smp_in.ad     = ad_i;
    smp_in.pwr_ok = pwr_ok_i;
    smp_in.rst_n  = bus_rst_ni;
    smp_in.rw     = rw_i;
    smp_in.cs_n   = cs_ni;
    smp_in.we_n   = we_ni;
    smp_in.ds     = ds_i;
    smp_in.as     = as_i;
  end

  hbus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SMP_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (smp_in),
    .cur_o  (smp_cur),
    .prev_o (smp_prev)
  );

  hbus_bus_fsm #(.CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_ds_i (mode_ds_i),
    .cur_i     (smp_cur),
    .prev_i    (smp_prev),
    .ctrl_rd_i (ctrl_rd),
    .flag_rd_i (flag_rd),
    .ext_rd_i  (reg_rdata_i),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .addr_o    (addr),
    .wdata_o   (wdata),
    .wr_o      (wr),
    .rd_end_o  (rd_end)
  );

  assign rst_clr = ~smp_cur.rst_n & smp_cur.pwr_ok;

  hbus_ctl_regs #(.CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_ok_i    (smp_cur.rst_n),
    .rst_clr_i   (rst_clr),
    .wr_i        (wr),
    .rd_end_i    (rd_end),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .evt_i       (evt_i),
    .ctrl_o      (ctrl_rd),
    .flag_o      (flag_rd),
    .irq_drive_o (irq_drive_o),
    .sqw_en_o    (sqw_en_o)
  );

  assign reg_addr_o  = addr;
  assign reg_wdata_o = wdata;
  assign reg_we_o    = wr & (addr != CTRL_ADDR) & (addr != FLAG_ADDR);

  p_no_drive_in_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_cur.rst_n |-> !ad_oe_o);
  p_irq_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_cur.rst_n |-> !irq_drive_o);
endmodule

// File: tb/tb_hbus_access_unit.sv
module tb_hbus_access_unit;
  localparam int          S  = 3;
  localparam logic [7:0]  CA = 8'h0B;
  localparam logic [7:0]  FA = 8'h0C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni, mode_ds_i, bus_rst_ni, pwr_ok_i, cs_ni, as_i, ds_i, rw_i, we_ni;
  logic [7:0] ad_i, ad_o, reg_addr_o, reg_wdata_o, reg_rdata_i;
  logic       ad_oe_o, reg_we_o, irq_drive_o, sqw_en_o;
  logic [2:0] evt_i;

  assign reg_rdata_i = reg_addr_o ^ 8'h5A;

  hbus_access_unit #(.SYNC_STAGES(S), .CTRL_ADDR(CA), .FLAG_ADDR(FA)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_ds_i(mode_ds_i), .bus_rst_ni(bus_rst_ni),
    .pwr_ok_i(pwr_ok_i), .cs_ni(cs_ni), .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i),
    .we_ni(we_ni), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
    .reg_rdata_i(reg_rdata_i), .evt_i(evt_i), .irq_drive_o(irq_drive_o),
    .sqw_en_o(sqw_en_o)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] mon_e;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every external write pulse is matched to the queue
  always @(negedge clk) begin
    if (rst_ni && reg_we_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R3 unexpected write act=%h exp=none", {reg_addr_o, reg_wdata_o});
      end else begin
        mon_e = exp_q.pop_front();
        chk("R3/R5 write pulse", {reg_addr_o, reg_wdata_o}, mon_e);
      end
    end
  end

  task automatic bus_addr(logic [7:0] a, bit cs);
    ad_i = a; cs_ni = ~cs; as_i = 1'b1;
    nclk(2);
    as_i = 1'b0;
    nclk(S + 2);
  endtask

  task automatic ds_write(logic [7:0] a, logic [7:0] d, bit cs, bit ext);
    if (ext) exp_q.push_back({a, d});
    bus_addr(a, cs);
    rw_i = 1'b0; ad_i = d; ds_i = 1'b1;
    nclk(3);
    ds_i = 1'b0;
    nclk(S + 3);
    rw_i = 1'b1;
  endtask

  task automatic ds_read(logic [7:0] a, logic [7:0] exp, string req);
    bus_addr(a, 1'b1);
    rw_i = 1'b1; ds_i = 1'b1;
    nclk(S + 1);
    chk(req, {7'd0, ad_oe_o, ad_o}, {7'd0, 1'b1, exp});
    ds_i = 1'b0;
    nclk(S + 2);
    chk({req, " release"}, {15'd0, ad_oe_o}, 16'd0);
  endtask

  task automatic oe_write(logic [7:0] a, logic [7:0] d, bit ext);
    if (ext) exp_q.push_back({a, d});
    bus_addr(a, 1'b1);
    ad_i = d; we_ni = 1'b0;
    nclk(3);
    we_ni = 1'b1;
    nclk(S + 3);
  endtask

  task automatic oe_read(logic [7:0] a, logic [7:0] exp);
    bus_addr(a, 1'b1);
    ds_i = 1'b0;
    nclk(S + 1);
    chk("R4 oe read", {7'd0, ad_oe_o, ad_o}, {7'd0, 1'b1, exp});
    ds_i = 1'b1;
    nclk(S + 2);
    chk("R4 oe release", {15'd0, ad_oe_o}, 16'd0);
  endtask

  task automatic pulse_evt(logic [2:0] e);
    evt_i = e;
    nclk(1);
    evt_i = 3'b000;
    nclk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; mode_ds_i = 1'b1; bus_rst_ni = 1'b1; pwr_ok_i = 1'b1;
    cs_ni = 1'b1; as_i = 1'b0; ds_i = 1'b0; rw_i = 1'b1; we_ni = 1'b1;
    ad_i = 8'h00; evt_i = 3'b000;
    nclk(3);
    rst_ni = 1'b1;
    nclk(S + 3);
    // R7 reset state: no drive, no irq, square wave off
    chk("R7 reset state", {12'd0, ad_oe_o, reg_we_o, irq_drive_o, sqw_en_o}, 16'd0);

    // strobe-pulse mode, external registers
    ds_write(8'h21, 8'hC3, 1'b1, 1'b1);
    ds_write(8'h3F, 8'h5A, 1'b1, 1'b1);
    ds_read(8'h21, 8'h21 ^ 8'h5A, "R2 ds read");
    ds_read(8'h7E, 8'h7E ^ 8'h5A, "R2 ds read");
    // R1: deselected cycles neither write nor drive
    ds_write(8'h40, 8'h99, 1'b0, 1'b0);
    bus_addr(8'h41, 1'b0);
    rw_i = 1'b1; ds_i = 1'b1;
    nclk(S + 1);
    chk("R1 deselected read", {15'd0, ad_oe_o}, 16'd0);
    ds_i = 1'b0;
    nclk(S + 2);
    // R3: internal control write, no external pulse
    ds_write(CA, 8'hAF, 1'b1, 1'b0);
    ds_read(CA, 8'hAF, "R3 ctrl readback");
    chk("R7 sqw enable", {15'd0, sqw_en_o}, 16'd1);

    // output-enable mode
    bus_addr(8'h00, 1'b0);
    mode_ds_i = 1'b0; ds_i = 1'b1; rw_i = 1'b1;
    nclk(S + 3);
    oe_write(8'h22, 8'h3C, 1'b1);
    oe_read(8'h22, 8'h22 ^ 8'h5A);
    oe_write(CA, 8'hA7, 1'b0);
    oe_read(CA, 8'hA7);
    bus_addr(8'h00, 1'b0);
    mode_ds_i = 1'b1; ds_i = 1'b0;
    nclk(S + 3);

    // R9: events with enables on raise irq
    pulse_evt(3'b111);
    nclk(S);
    chk("R9 irq with enables", {15'd0, irq_drive_o}, 16'd1);

    // R6/R7: reset in the middle of a write
    bus_addr(8'h55, 1'b1);
    rw_i = 1'b0; ad_i = 8'h66; ds_i = 1'b1;
    nclk(1);
    bus_rst_ni = 1'b0;
    nclk(S + 2);
    ds_i = 1'b0;
    nclk(S + 3);
    rw_i = 1'b1;
    chk("R7 irq released in reset", {15'd0, irq_drive_o}, 16'd0);
    chk("R7 sqw cleared in reset", {15'd0, sqw_en_o}, 16'd0);
    // R6: full cycle during reset is ignored
    ds_write(8'h56, 8'h77, 1'b1, 1'b0);
    bus_addr(8'h57, 1'b1);
    ds_i = 1'b1;
    nclk(S + 1);
    chk("R6 no drive in reset", {15'd0, ad_oe_o}, 16'd0);
    ds_i = 1'b0;
    nclk(S + 2);
    bus_rst_ni = 1'b1;
    nclk(S + 3);
    ds_read(CA, 8'hA0, "R7 ctrl low cleared high kept");
    ds_read(FA, 8'h00, "R7 flags cleared");
    ds_write(8'h58, 8'h12, 1'b1, 1'b1);

    // R6: reset during a read drops the drive
    bus_addr(8'h30, 1'b1);
    rw_i = 1'b1; ds_i = 1'b1;
    nclk(S + 1);
    chk("R6 read before reset", {7'd0, ad_oe_o, ad_o}, {7'd0, 1'b1, 8'h30 ^ 8'h5A});
    bus_rst_ni = 1'b0;
    nclk(S + 1);
    chk("R6 drive dropped", {15'd0, ad_oe_o}, 16'd0);
    ds_i = 1'b0;
    bus_rst_ni = 1'b1;
    nclk(S + 3);

    // R9: flags without enable, clear on read
    pulse_evt(3'b010);
    nclk(S);
    chk("R9 no irq when disabled", {15'd0, irq_drive_o}, 16'd0);
    ds_read(FA, 8'h02, "R9 flag set");
    ds_read(FA, 8'h00, "R9 flag cleared by read");
    ds_write(CA, 8'hA2, 1'b1, 1'b0);
    pulse_evt(3'b010);
    nclk(S);
    chk("R9 irq with alarm enable", {15'd0, irq_drive_o}, 16'd1);
    ds_read(FA, 8'h82, "R9 summary bit");
    ds_read(FA, 8'h00, "R9 cleared again");
    chk("R9 irq cleared", {15'd0, irq_drive_o}, 16'd0);

    // R8: reset during power fail keeps control byte
    ds_write(CA, 8'h5C, 1'b1, 1'b0);
    pwr_ok_i = 1'b0;
    nclk(S + 2);
    bus_rst_ni = 1'b0;
    nclk(S + 4);
    bus_rst_ni = 1'b1;
    nclk(S + 2);
    pwr_ok_i = 1'b1;
    nclk(S + 2);
    ds_read(CA, 8'h5C, "R8 ctrl kept under power fail");

    nclk(5);
    chk("R3 all writes seen", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule